// File: doc/BRIEF.md
# Netlist Record Bitstream Decoder

This block turns a bit-serial stream holding a compressed transistor netlist back into one record per transistor. Each record has three node numbers: the gate node and the two channel nodes, called c1 and c2. Bits arrive one per clock over a valid/ready handshake. Finished records leave on a second valid/ready port.

The gate node is sent as a single step bit against the gate of the record before it. The c1 node uses a short prefix code, so the ground node and the supply node each take one or two bits. A raw node number takes a two-bit escape and then the full number. The c2 node is always sent raw.

As an option, a run can begin with a raw per-node pullup bitmap. Its bits pass out one at a time on a third port before any record is decoded. The software sets the record count, the node count and the pullup option and then pulses `start`. The block raises `done` once the last record has been taken in, and accepts no more bits until the next `start`.

Top module: `netlist_rec_decoder`

## Requirements
- R1: After reset, `bit_ready`, `rec_valid`, `pu_valid` and `done` are all 0, and no bit is accepted until `start` is pulsed.
- R2: The gate step bit is 0 for "same gate as the previous record" and 1 for "previous gate plus one", with 11-bit wrap-around. The first record after `start` steps from node 2047 (−1), so a first step bit of 1 gives gate 0 and a first step bit of 0 gives gate 2047.
- R3: The c1 field is coded by prefix. A first bit of 1 means node 558 (ground). The bits 0 then 1 mean node 657 (supply). The bits 0 then 0 are followed by an 11-bit node number, sent MSB first.
- R4: The c2 field is an 11-bit node number, sent MSB first, right after the c1 field. Each record is sent as gate bit, then c1 code, then c2 bits.
- R5: When `pull_en` is 1 at `start` and `node_count` is nonzero, the first `node_count` stream bits come out on `pu_bit`, one per accepted bit and in stream order, before any record bit is decoded. When `pull_en` is 0, no pullup bit is presented.
- R6: Once `rec_count` records have been loaded, `done` is 1 and `bit_ready` stays 0 even while `bit_valid` is held, until the next `start`.
- R7: While `rec_valid` is 1 and `rec_ready` is 0, the record stays presented with unchanged fields. The final c2 bit of the next record is not accepted until the output slot frees, so no record is lost.
- R8: While `pu_valid` is 1 and `pu_ready` is 0, `pu_bit` is held unchanged and no further pullup bit is accepted.
- R9: While both output ports are ready and `bit_valid` stays high, the block accepts one bit on every clock, with no stall, from `start` until `done`.
- R10: A `start` with `rec_count` 0, and with no pullup phase, sets `done` on the next clock edge.
- R11: A `start` pulse in the middle of a record drops the partial record, sets gate tracking back to −1 and begins a new run. A bit offered during the `start` cycle is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that latches the configuration and begins a run |
| pull_en | input | 1 | When 1, the run begins with a pullup bitmap phase |
| node_count | input | 16 | Number of pullup bits in the bitmap phase |
| rec_count | input | 16 | Number of records in the run |
| bit_valid | input | 1 | Stream bit is offered |
| bit_data | input | 1 | Stream bit value |
| bit_ready | output | 1 | Stream bit is accepted on this edge when valid |
| pu_valid | output | 1 | Pullup bit is presented |
| pu_bit | output | 1 | Pullup bit value (1 = node has a pullup) |
| pu_ready | input | 1 | Consumer takes the pullup bit |
| rec_valid | output | 1 | Record is presented |
| rec_gate | output | 11 | Gate node of the record |
| rec_c1 | output | 11 | c1 node of the record |
| rec_c2 | output | 11 | c2 node of the record |
| rec_ready | input | 1 | Consumer takes the record |
| done | output | 1 | Configured number of records has been decoded |

## Verification
The random runs mix all three c1 code kinds, with gate steps of 0 and 1, under random gaps on the input and random backpressure on both outputs. A wrong prefix decode or a misplaced MSB-first field therefore shows up as a field mismatch rather than as a lost bit. A run with no gaps and no backpressure separates a decoder that takes one bit per clock from one that inserts bubbles at field edges. Directed runs cover a first step bit of 0 (gate 2047), a record count of zero, a pullup-only run and a restart in the middle of a record. These runs tell apart correct reset of the gate tracking and of the counters from state that leaks from one run into the next.

// File: rtl/ndec_pkg.sv
`timescale 1ns/1ps
package ndec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULL,
        ST_GATE,
        ST_C1_FIRST,
        ST_C1_SECOND,
        ST_C1_RAW,
        ST_C2_RAW,
        ST_DONE
    } ndec_state_e;

endpackage

// File: rtl/ndec_out_slot.sv
`timescale 1ns/1ps
module ndec_out_slot #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    input  logic         ready_i,
    output logic         valid_o,
    output logic [W-1:0] dout_o,
    output logic         free_o
);

    typedef struct packed {
        logic         v;
        logic [W-1:0] d;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.v && ready_i) begin
            slot_d.v = 1'b0;
        end
        if (load_i) begin
            slot_d.v = 1'b1;
            slot_d.d = din_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign valid_o = slot_q.v;
    assign dout_o  = slot_q.d;
    assign free_o  = !slot_q.v || ready_i;

    // R7 R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(dout_o)));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (!valid_o || ready_i));

endmodule

// File: rtl/ndec_ctrl.sv
`timescale 1ns/1ps
module ndec_ctrl
    import ndec_pkg::*;
#(
    parameter int NODE_W   = 11,
    parameter int CNT_W    = 16,
    parameter int GND_NODE = 558,
    parameter int VCC_NODE = 657
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pull_en_i,
    input  logic [CNT_W-1:0]  node_count_i,
    input  logic [CNT_W-1:0]  rec_count_i,
    input  logic              bit_valid_i,
    input  logic              bit_i,
    output logic              bit_ready_o,
    input  logic              pu_free_i,
    input  logic              rec_free_i,
    output logic              pu_load_o,
    output logic              pu_bit_o,
    output logic              rec_load_o,
    output logic [NODE_W-1:0] rec_gate_o,
    output logic [NODE_W-1:0] rec_c1_o,
    output logic [NODE_W-1:0] rec_c2_o,
    output logic              done_o
);

    localparam int                BW       = $clog2(NODE_W);
    localparam logic [BW-1:0]     LAST_BIT = BW'(NODE_W - 1);
    localparam logic [NODE_W-1:0] GND_C    = NODE_W'(GND_NODE);
    localparam logic [NODE_W-1:0] VCC_C    = NODE_W'(VCC_NODE);
    localparam logic [CNT_W-1:0]  ONE_CNT  = CNT_W'(1);

    typedef struct packed {
        ndec_state_e       st;
        logic [NODE_W-1:0] gate;
        logic [NODE_W-1:0] c1;
        logic [NODE_W-1:0] c2;
        logic [BW-1:0]     bcnt;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  nlim;
        logic [CNT_W-1:0]  rlim;
    } ctrl_t;

    ctrl_t             ctl_d, ctl_q;
    logic              rdy;
    logic              take;
    logic [NODE_W-1:0] c1_shift;
    logic [NODE_W-1:0] c2_shift;
    logic [CNT_W-1:0]  cnt_inc;

    assign c1_shift = {ctl_q.c1[NODE_W-2:0], bit_i};
    assign c2_shift = {ctl_q.c2[NODE_W-2:0], bit_i};
    assign cnt_inc  = ctl_q.cnt + ONE_CNT;

    always_comb begin
        ctl_d      = ctl_q;
        rdy        = 1'b0;
        pu_load_o  = 1'b0;
        rec_load_o = 1'b0;

        case (ctl_q.st)
            ST_PULL:                                   rdy = pu_free_i;
            ST_GATE, ST_C1_FIRST, ST_C1_SECOND, ST_C1_RAW: rdy = 1'b1;
            ST_C2_RAW:                                 rdy = (ctl_q.bcnt != '0) || rec_free_i;
            default:                                   rdy = 1'b0;
        endcase
        if (start_i) begin
            rdy = 1'b0;
        end
        take = bit_valid_i && rdy;

        if (start_i) begin
            ctl_d.gate = '1;
            ctl_d.cnt  = '0;
            ctl_d.bcnt = '0;
            ctl_d.nlim = node_count_i;
            ctl_d.rlim = rec_count_i;
            if (pull_en_i && (node_count_i != '0)) begin
                ctl_d.st = ST_PULL;
            end else if (rec_count_i != '0) begin
                ctl_d.st = ST_GATE;
            end else begin
                ctl_d.st = ST_DONE;
            end
        end else if (take) begin
            case (ctl_q.st)
                ST_PULL: begin
                    pu_load_o = 1'b1;
                    if (cnt_inc == ctl_q.nlim) begin
                        ctl_d.cnt = '0;
                        ctl_d.st  = (ctl_q.rlim == '0) ? ST_DONE : ST_GATE;
                    end else begin
                        ctl_d.cnt = cnt_inc;
                    end
                end
                ST_GATE: begin
                    ctl_d.gate = ctl_q.gate + {{(NODE_W-1){1'b0}}, bit_i};
                    ctl_d.st   = ST_C1_FIRST;
                end
                ST_C1_FIRST: begin
                    if (bit_i) begin
                        ctl_d.c1   = GND_C;
                        ctl_d.bcnt = LAST_BIT;
                        ctl_d.st   = ST_C2_RAW;
                    end else begin
                        ctl_d.st   = ST_C1_SECOND;
                    end
                end
                ST_C1_SECOND: begin
                    ctl_d.bcnt = LAST_BIT;
                    if (bit_i) begin
                        ctl_d.c1 = VCC_C;
                        ctl_d.st = ST_C2_RAW;
                    end else begin
                        ctl_d.st = ST_C1_RAW;
                    end
                end
                ST_C1_RAW: begin
                    ctl_d.c1 = c1_shift;
                    if (ctl_q.bcnt == '0) begin
                        ctl_d.bcnt = LAST_BIT;
                        ctl_d.st   = ST_C2_RAW;
                    end else begin
                        ctl_d.bcnt = ctl_q.bcnt - BW'(1);
                    end
                end
                ST_C2_RAW: begin
                    ctl_d.c2 = c2_shift;
                    if (ctl_q.bcnt == '0) begin
                        rec_load_o = 1'b1;
                        ctl_d.cnt  = cnt_inc;
                        ctl_d.st   = (cnt_inc == ctl_q.rlim) ? ST_DONE : ST_GATE;
                    end else begin
                        ctl_d.bcnt = ctl_q.bcnt - BW'(1);
                    end
                end
                default: ctl_d = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.gate <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bit_ready_o = rdy;
    assign pu_bit_o    = bit_i;
    assign rec_gate_o  = ctl_q.gate;
    assign rec_c1_o    = ctl_q.c1;
    assign rec_c2_o    = c2_shift;
    assign done_o      = (ctl_q.st == ST_DONE);

    logic [NODE_W-1:0] last_gate_q;
    logic              have_last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_gate_q <= '0;
            have_last_q <= 1'b0;
        end else if (start_i) begin
            have_last_q <= 1'b0;
        end else if (rec_load_o) begin
            last_gate_q <= rec_gate_o;
            have_last_q <= 1'b1;
        end
    end

    // R2
    gate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_load_o && have_last_q) |->
            ((rec_gate_o == last_gate_q) || (rec_gate_o == last_gate_q + NODE_W'(1))));

    // R6
    done_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !bit_ready_o);

    // R6
    done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(rec_load_o) || $past(pu_load_o) || $past(start_i)));

endmodule

// File: rtl/netlist_rec_decoder.sv
`timescale 1ns/1ps
module netlist_rec_decoder #(
    parameter int NODE_W   = 11,
    parameter int CNT_W    = 16,
    parameter int GND_NODE = 558,
    parameter int VCC_NODE = 657
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pull_en,
    input  logic [CNT_W-1:0]  node_count,
    input  logic [CNT_W-1:0]  rec_count,
    input  logic              bit_valid,
    input  logic              bit_data,
    output logic              bit_ready,
    output logic              pu_valid,
    output logic              pu_bit,
    input  logic              pu_ready,
    output logic              rec_valid,
    output logic [NODE_W-1:0] rec_gate,
    output logic [NODE_W-1:0] rec_c1,
    output logic [NODE_W-1:0] rec_c2,
    input  logic              rec_ready,
    output logic              done
);

    localparam int REC_W = 3 * NODE_W;

    logic              pu_free, rec_free, pu_load, rec_load, pu_in;
    logic [NODE_W-1:0] g_w, c1_w, c2_w;
    logic [REC_W-1:0]  rec_out;

    ndec_ctrl #(
        .NODE_W  (NODE_W),
        .CNT_W   (CNT_W),
        .GND_NODE(GND_NODE),
        .VCC_NODE(VCC_NODE)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .pull_en_i   (pull_en),
        .node_count_i(node_count),
        .rec_count_i (rec_count),
        .bit_valid_i (bit_valid),
        .bit_i       (bit_data),
        .bit_ready_o (bit_ready),
        .pu_free_i   (pu_free),
        .rec_free_i  (rec_free),
        .pu_load_o   (pu_load),
        .pu_bit_o    (pu_in),
        .rec_load_o  (rec_load),
        .rec_gate_o  (g_w),
        .rec_c1_o    (c1_w),
        .rec_c2_o    (c2_w),
        .done_o      (done)
    );

    ndec_out_slot #(.W(1)) u_pu_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (pu_load),
        .din_i  (pu_in),
        .ready_i(pu_ready),
        .valid_o(pu_valid),
        .dout_o (pu_bit),
        .free_o (pu_free)
    );

    ndec_out_slot #(.W(REC_W)) u_rec_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (rec_load),
        .din_i  ({g_w, c1_w, c2_w}),
        .ready_i(rec_ready),
        .valid_o(rec_valid),
        .dout_o (rec_out),
        .free_o (rec_free)
    );

    assign rec_gate = rec_out[REC_W-1 -: NODE_W];
    assign rec_c1   = rec_out[2*NODE_W-1 -: NODE_W];
    assign rec_c2   = rec_out[NODE_W-1:0];

endmodule

// File: tb/netlist_rec_decoder_bench.sv
`timescale 1ns/1ps
module netlist_rec_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n, start, pull_en, bit_valid, bit_data, pu_ready, rec_ready;
    logic [15:0] node_count, rec_count;
    logic        bit_ready, pu_valid, pu_bit, rec_valid, done;
    logic [10:0] rec_gate, rec_c1, rec_c2;

    always #2.5 clk = ~clk;

    netlist_rec_decoder u_netlist_rec_decoder (
        .clk(clk), .rst_n(rst_n), .start(start), .pull_en(pull_en),
        .node_count(node_count), .rec_count(rec_count),
        .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
        .pu_valid(pu_valid), .pu_bit(pu_bit), .pu_ready(pu_ready),
        .rec_valid(rec_valid), .rec_gate(rec_gate), .rec_c1(rec_c1),
        .rec_c2(rec_c2), .rec_ready(rec_ready), .done(done)
    );

    int n_cmp = 0;
    int n_bad = 0;

    bit          stream [0:16383];
    int          n_bits;
    logic [10:0] eg [0:511];
    logic [10:0] ec1 [0:511];
    logic [10:0] ec2 [0:511];
    bit          ep [0:2047];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(int v, int w);
        for (int i = w - 1; i >= 0; i--) begin
            stream[n_bits] = v[i];
            n_bits++;
        end
    endtask

    task automatic build(int nrec, int npull, bit pen, bit first_zero);
        int g = 2047;
        n_bits = 0;
        for (int i = 0; i < npull; i++) begin
            ep[i] = 1'($urandom % 2);
            if (pen) put(int'(ep[i]), 1);
        end
        for (int i = 0; i < nrec; i++) begin
            int step = (i == 0) ? (first_zero ? 0 : 1) : int'($urandom % 2);
            int kind = int'($urandom % 3);
            g = (g + step) & 2047;
            eg[i] = 11'(g);
            put(step, 1);
            if (kind == 0) begin
                ec1[i] = 11'd558; put(1, 1);
            end else if (kind == 1) begin
                ec1[i] = 11'd657; put(1, 2);
            end else begin
                ec1[i] = 11'($urandom % 2048); put(0, 2); put(int'(ec1[i]), 11);
            end
            ec2[i] = 11'($urandom % 2048);
            put(int'(ec2[i]), 11);
        end
    endtask

    task automatic run_case(int nrec, int npull, bit pen, bit first_zero,
                            int vpct, int rpct, bit tp);
        int stalls = 0;
        build(nrec, npull, pen, first_zero);
        @(negedge clk);
        bit_valid = 1'b0; pull_en = pen;
        node_count = 16'(npull); rec_count = 16'(nrec); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            begin
                int idx = 0;
                while (idx < n_bits) begin
                    bit_valid = (($urandom % 100) < vpct);
                    bit_data  = stream[idx];
                    #1;
                    if (tp && bit_valid && !bit_ready) stalls++;
                    if (bit_valid && bit_ready) idx++;
                    @(negedge clk);
                end
                bit_valid = 1'b0;
            end
            begin
                int got = 0;
                bit hold = 0;
                logic [32:0] held = '0;
                while (got < nrec) begin
                    rec_ready = (($urandom % 100) < rpct);
                    #1;
                    if (hold) chk(rec_valid && ({rec_gate, rec_c1, rec_c2} == held), "R7",
                                  "held record", longint'({rec_valid, rec_gate, rec_c1, rec_c2}),
                                  longint'({1'b1, held}));
                    hold = 0;
                    if (rec_valid) begin
                        if (rec_ready) begin
                            chk(rec_gate == eg[got], "R2", "gate", longint'(rec_gate), longint'(eg[got]));
                            chk(rec_c1 == ec1[got], "R3", "c1", longint'(rec_c1), longint'(ec1[got]));
                            chk(rec_c2 == ec2[got], "R4", "c2", longint'(rec_c2), longint'(ec2[got]));
                            got++;
                        end else begin
                            hold = 1;
                            held = {rec_gate, rec_c1, rec_c2};
                        end
                    end
                    @(negedge clk);
                end
            end
            begin
                int got = 0;
                int want = pen ? npull : 0;
                bit hold = 0;
                bit held = 0;
                while (got < want) begin
                    pu_ready = (($urandom % 100) < rpct);
                    #1;
                    if (hold) chk(pu_valid && (pu_bit == held), "R8", "held pullup",
                                  longint'({pu_valid, pu_bit}), longint'({1'b1, held}));
                    hold = 0;
                    if (pu_valid) begin
                        if (pu_ready) begin
                            chk(pu_bit == ep[got], "R5", "pullup bit", longint'(pu_bit), longint'(ep[got]));
                            got++;
                        end else begin
                            hold = 1; held = pu_bit;
                        end
                    end
                    @(negedge clk);
                end
            end
        join
        @(negedge clk);
        #1;
        chk(done == 1'b1, "R6", "done after run", longint'(done), 1);
        chk(bit_ready == 1'b0, "R6", "ready after run", longint'(bit_ready), 0);
        chk(rec_valid == 1'b0 && pu_valid == 1'b0, "R5", "no extra output",
            longint'({rec_valid, pu_valid}), 0);
        if (tp) chk(stalls == 0, "R9", "input stalls", longint'(stalls), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1725));
        rst_n = 1'b0; start = 1'b0; pull_en = 1'b0; bit_valid = 1'b0; bit_data = 1'b0;
        pu_ready = 1'b1; rec_ready = 1'b1; node_count = '0; rec_count = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        bit_valid = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state and no acceptance before start
        chk(bit_ready == 1'b0, "R1", "bit_ready", longint'(bit_ready), 0);
        chk(rec_valid == 1'b0, "R1", "rec_valid", longint'(rec_valid), 0);
        chk(pu_valid == 1'b0, "R1", "pu_valid", longint'(pu_valid), 0);
        chk(done == 1'b0, "R1", "done", longint'(done), 0);
        bit_valid = 1'b0;

        // R10 zero records, no pullup phase
        @(negedge clk);
        pull_en = 1'b0; node_count = 16'd5; rec_count = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(done == 1'b1, "R10", "done after empty start", longint'(done), 1);
        chk(bit_ready == 1'b0, "R10", "ready after empty start", longint'(bit_ready), 0);

        // R5 pullup-only run
        run_case(0, 37, 1'b1, 1'b0, 70, 60, 1'b0);
        // R2 R3 R4 R5 R7 R8 main random run
        run_case(150, 90, 1'b1, 1'b0, 60, 50, 1'b0);
        // R9 full throughput
        run_case(60, 20, 1'b1, 1'b0, 100, 100, 1'b1);
        // R2 first step bit zero gives gate 2047
        run_case(5, 3, 1'b0, 1'b1, 80, 80, 1'b0);

        // R11 restart in the middle of a record
        @(negedge clk);
        pull_en = 1'b0; rec_count = 16'd10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 7; i++) begin
            bit_valid = 1'b1; bit_data = 1'b1;
            @(negedge clk);
        end
        bit_valid = 1'b0;
        #1;
        chk(rec_valid == 1'b0, "R11", "no record from partial bits", longint'(rec_valid), 0);
        run_case(10, 4, 1'b0, 1'b0, 90, 40, 1'b0);

        // R6 done stalls the stream
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            bit_valid = 1'b1; bit_data = 1'b0;
            #1;
            chk(bit_ready == 1'b0, "R6", "ready while done", longint'(bit_ready), 0);
            chk(rec_valid == 1'b0, "R6", "record while done", longint'(rec_valid), 0);
        end
        bit_valid = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule